// File: doc/BRIEF.md
# Two-Wire Debug Target Port

This block is the target end of a two-wire synchronous debug link. The host supplies the clock and shares a single bidirectional data line with the target. The block samples an 8-bit request on the data line and checks its framing and parity. It answers with a 3-bit acknowledge. It then either shifts in 33 bits of write data from the host or shifts out 33 bits of read data, which is 32 data bits followed by even parity. Every field moves least significant bit first. Whenever the line changes direction, the block inserts one bit period in which its output enable is low. The bench models the host side of that gap.

Requests address one of two banks. The debug-port bank is local and holds four words: an identity word, a status word, a select word and a buffer for read results. Access-port requests are passed on to a single-outstanding valid/ready request channel with a separate response strobe. The address sent on that channel is built from the access-port number and bank window held in the select word, together with the two address bits of the request. Access-port reads are posted: the data returned in a read's data phase is the result of the access-port read before it, and the new read is launched at the same moment.

The link controller is a state machine with seven states. ST_IDLE waits for a start bit and goes to ST_REQ. ST_REQ collects the eight request bits and then goes to ST_TURN_RX2TX if the request is well formed, or back to ST_IDLE if it is not. ST_TURN_RX2TX lasts one cycle and goes to ST_ACK. ST_ACK drives three bits and then goes to ST_RDATA for a read that was given OK, or to ST_TURN_TX2RX otherwise. ST_RDATA drives 33 bits and goes to ST_TURN_TX2RX. ST_TURN_TX2RX lasts one cycle and goes to ST_WDATA for a write that was given OK, or to ST_IDLE otherwise. ST_WDATA samples 33 bits, commits the write and returns to ST_IDLE.

Top module: `swdt_target`

## Requirements
- R1: The request is 8 bits, sent first bit first. Its bits are: bit0 start = 1, bit1 bank (0 = debug port, 1 = access port), bit2 direction (0 = write, 1 = read), bit3 = A[2], bit4 = A[3], bit5 = even parity over bits 1..4, bit6 stop = 0, bit7 park = 1. A well-formed request is answered.
- R2: A request with a wrong start, stop, park or parity bit is ignored. The line is not driven, no acknowledge is sent, and the next well-formed request is served normally.
- R3: One undriven cycle (sw_oe low) separates the request from the acknowledge. Another undriven cycle comes after the acknowledge of a write or of a refused access, and another after the read data. The acknowledge is 3 bits, least significant bit first: OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100.
- R4: For a read given OK, the target drives 32 data bits, least significant bit first, and then one bit of even parity over them.
- R5: For a write given OK, the host sends 32 data bits and then even parity over them. If the parity is wrong, the write is discarded and a sticky error flag is set.
- R6: The debug-port words are selected by A[3:2]. 00 reads the ID_VALUE parameter; a write to 00 with bit0 = 1 clears the sticky error. 01 reads status, with bit0 = sticky error and bit1 = access-port request outstanding; writes to it are ignored. 10 is the select word: bits 31:24 hold the access-port number and bits 7:4 the bank window, and all other bits read 0. 11 reads the buffer of read results; writes to it are ignored.
- R7: An access-port request presents ap_req_addr = {select[31:24], select[7:4], A[3:2]}, together with ap_req_write and ap_req_wdata. It holds all of them steady while ap_req_valid is high and ap_req_ready is low.
- R8: Access-port reads are posted. The data phase returns the buffered result of the previous access-port read (0 after reset), and a new access-port read is launched. A debug-port read at address 11 returns the same buffer without launching a request.
- R9: An access-port request sent while an earlier one has not yet had its response gets WAIT. It gets no data phase and causes no new request, and at most one request is ever outstanding.
- R10: While the sticky error is set, an access-port request gets FAULT and causes no request. Debug-port requests always get OK.
- R11: After reset the line is undriven, no request is valid, the select word and the read buffer are 0, and the sticky error is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-driven link clock |
| rst_n | input | 1 | Active-low reset |
| sw_in | input | 1 | Value seen on the data line |
| sw_out | output | 1 | Value the target drives onto the data line |
| sw_oe | output | 1 | Output enable of the data line driver |
| ap_req_valid | output | 1 | Access-port request valid |
| ap_req_ready | input | 1 | Access-port request accepted |
| ap_req_write | output | 1 | Request is a write |
| ap_req_addr | output | APSEL_W+BANK_W+2 | {port number, bank window, A[3:2]} |
| ap_req_wdata | output | 32 | Write data of the request |
| ap_rsp_valid | input | 1 | Response strobe for the outstanding request |
| ap_rsp_rdata | input | 32 | Read result sent with the response |

## Verification
A wrong state in the link controller shows up on sw_oe within a few cycles. The line would be driven in a turnaround slot, the acknowledge would be shifted by a cycle, or the line would not be released after the parity bit. The host's sample of the acknowledge, or the cycle after the data, exposes all of these within one transaction. A lost or stuck outstanding flag shows up as a wrong WAIT or OK on the next access-port request, and also in status bit1. A corrupted read buffer shows up in the next posted read and in the debug-port read at address 11, with no extra request on the channel.

// File: rtl/swdt_pkg.sv
package swdt_pkg;

    localparam int DATA_W = 32;
    localparam int REQ_W  = 8;
    localparam int CNT_W  = 6;

    // request bit positions (wire order)
    localparam int RQ_START = 0;
    localparam int RQ_BANK  = 1;
    localparam int RQ_DIR   = 2;
    localparam int RQ_A2    = 3;
    localparam int RQ_A3    = 4;
    localparam int RQ_PAR   = 5;
    localparam int RQ_STOP  = 6;
    localparam int RQ_PARK  = 7;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_TURN_RX2TX,
        ST_ACK,
        ST_RDATA,
        ST_TURN_TX2RX,
        ST_WDATA
    } link_state_e;

    typedef struct packed {
        logic       ap;
        logic       rd;
        logic [1:0] a;
    } req_t;

endpackage

// File: rtl/swdt_link.sv
module swdt_link
    import swdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_in,
    output logic              sw_out,
    output logic              sw_oe,
    input  logic              ap_busy,
    input  logic              sticky_err,
    input  logic [DATA_W-1:0] rd_value,
    output logic              dec_ap,
    output logic [1:0]        dec_a,
    output logic              rd_launch,
    output logic              wr_commit,
    output logic              wr_par_err,
    output logic              wr_ap,
    output logic [1:0]        wr_a,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [CNT_W-1:0] LAST_REQ  = CNT_W'(REQ_W - 1);
    localparam logic [CNT_W-1:0] LAST_ACK  = CNT_W'(2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);

    link_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [REQ_W-1:0]  req_sh_q;
    logic [REQ_W-1:0]  full_req;
    req_t              req_q, dec;
    logic [2:0]        ack_q, ack_sel;
    logic [DATA_W-1:0] rsh_q, wsh_q;
    logic              rpar_q;
    logic              req_ok, last_req, wpar_ok, data_end;

    // decode of the request as its final bit arrives
    always_comb begin
        full_req = {sw_in, req_sh_q[REQ_W-1:1]};
        req_ok   = full_req[RQ_START] && !full_req[RQ_STOP] && full_req[RQ_PARK]
                   && (full_req[RQ_PAR] == ^full_req[RQ_A3:RQ_BANK]);
        dec.ap   = full_req[RQ_BANK];
        dec.rd   = full_req[RQ_DIR];
        dec.a    = {full_req[RQ_A3], full_req[RQ_A2]};
        last_req = (state_q == ST_REQ) && (cnt_q == LAST_REQ);
        data_end = (cnt_q == LAST_DATA);
        wpar_ok  = ((^wsh_q) == sw_in);
        if (!dec.ap)        ack_sel = ACK_OK;
        else if (sticky_err) ack_sel = ACK_FAULT;
        else if (ap_busy)   ack_sel = ACK_WAIT;
        else                ack_sel = ACK_OK;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (sw_in) state_d = ST_REQ;
            ST_REQ:        if (cnt_q == LAST_REQ)
                               state_d = req_ok ? ST_TURN_RX2TX : ST_IDLE;
            ST_TURN_RX2TX: state_d = ST_ACK;
            ST_ACK:        if (cnt_q == LAST_ACK)
                               state_d = (ack_q == ACK_OK && req_q.rd) ? ST_RDATA
                                                                      : ST_TURN_TX2RX;
            ST_RDATA:      if (data_end) state_d = ST_TURN_TX2RX;
            ST_TURN_TX2RX: state_d = (ack_q == ACK_OK && !req_q.rd) ? ST_WDATA : ST_IDLE;
            ST_WDATA:      if (data_end) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
        if (state_q == ST_IDLE && state_d == ST_REQ) cnt_d = CNT_W'(1);
        else if (state_d != state_q)                 cnt_d = '0;
        else                                         cnt_d = cnt_q + CNT_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // shift paths and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sh_q <= '0;
            req_q    <= '0;
            ack_q    <= '0;
            rsh_q    <= '0;
            rpar_q   <= 1'b0;
            wsh_q    <= '0;
        end else begin
            if (state_q == ST_IDLE || state_q == ST_REQ)
                req_sh_q <= full_req;
            if (last_req && req_ok) begin
                req_q  <= dec;
                ack_q  <= ack_sel;
                rsh_q  <= rd_value;
                rpar_q <= ^rd_value;
            end
            if (state_q == ST_RDATA && !data_end)
                rsh_q <= {1'b0, rsh_q[DATA_W-1:1]};
            if (state_q == ST_WDATA && !data_end)
                wsh_q <= {sw_in, wsh_q[DATA_W-1:1]};
        end
    end

    // outputs
    always_comb begin
        sw_oe      = 1'b0;
        sw_out     = 1'b0;
        unique case (state_q)
            ST_ACK: begin
                sw_oe  = 1'b1;
                sw_out = ack_q[cnt_q[1:0]];
            end
            ST_RDATA: begin
                sw_oe  = 1'b1;
                sw_out = data_end ? rpar_q : rsh_q[0];
            end
            default: ;
        endcase
        dec_ap     = dec.ap;
        dec_a      = dec.a;
        rd_launch  = last_req && req_ok && dec.ap && dec.rd && (ack_sel == ACK_OK);
        wr_commit  = (state_q == ST_WDATA) && data_end && wpar_ok;
        wr_par_err = (state_q == ST_WDATA) && data_end && !wpar_ok;
        wr_ap      = req_q.ap;
        wr_a       = req_q.a;
        wr_data    = wsh_q;
    end

endmodule

// File: rtl/swdt_dp_regs.sv
module swdt_dp_regs
    import swdt_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h5A1D_0C01,
    parameter int APSEL_W = 8,
    parameter int BANK_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_commit,
    input  logic                    wr_ap,
    input  logic [1:0]              wr_a,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    wr_par_err,
    input  logic                    ap_pend,
    input  logic [DATA_W-1:0]       rdbuf,
    output logic [APSEL_W-1:0]      sel_port,
    output logic [BANK_W-1:0]       sel_bank,
    output logic                    sticky_err,
    output logic [3:0][DATA_W-1:0]  dp_rd
);

    localparam int PORT_LSB = 24;
    localparam int BANK_LSB = 4;
    localparam logic [DATA_W-1:0] SEL_MASK =
        ((DATA_W'(1) << APSEL_W) - DATA_W'(1)) << PORT_LSB |
        ((DATA_W'(1) << BANK_W)  - DATA_W'(1)) << BANK_LSB;

    logic [DATA_W-1:0] sel_q;
    logic              err_q;
    logic              dp_wr;

    assign dp_wr = wr_commit && !wr_ap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (wr_par_err)
                err_q <= 1'b1;
            else if (dp_wr && wr_a == 2'b00 && wr_data[0])
                err_q <= 1'b0;
            if (dp_wr && wr_a == 2'b10)
                sel_q <= wr_data & SEL_MASK;
        end
    end

    assign sel_port   = sel_q[PORT_LSB +: APSEL_W];
    assign sel_bank   = sel_q[BANK_LSB +: BANK_W];
    assign sticky_err = err_q;

    for (genvar i = 0; i < 4; i++) begin : g_rd
        if (i == 0)      assign dp_rd[i] = ID_VALUE;
        else if (i == 1) assign dp_rd[i] = {{(DATA_W-2){1'b0}}, ap_pend, err_q};
        else if (i == 2) assign dp_rd[i] = sel_q;
        else             assign dp_rd[i] = rdbuf;
    end

endmodule

// File: rtl/swdt_ap_port.sv
module swdt_ap_port
    import swdt_pkg::*;
#(
    parameter int APSEL_W = 8,
    parameter int BANK_W  = 4,
    localparam int AW = APSEL_W + BANK_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_launch,
    input  logic [1:0]         rd_a,
    input  logic               wr_go,
    input  logic [1:0]         wr_a,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [APSEL_W-1:0] sel_port,
    input  logic [BANK_W-1:0]  sel_bank,
    output logic               ap_req_valid,
    input  logic               ap_req_ready,
    output logic               ap_req_write,
    output logic [AW-1:0]      ap_req_addr,
    output logic [DATA_W-1:0]  ap_req_wdata,
    input  logic               ap_rsp_valid,
    input  logic [DATA_W-1:0]  ap_rsp_rdata,
    output logic               pend,
    output logic [DATA_W-1:0]  rdbuf
);

    logic is_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ap_req_valid <= 1'b0;
            ap_req_write <= 1'b0;
            ap_req_addr  <= '0;
            ap_req_wdata <= '0;
            pend         <= 1'b0;
            is_rd_q      <= 1'b0;
            rdbuf        <= '0;
        end else begin
            if (rd_launch) begin
                ap_req_valid <= 1'b1;
                ap_req_write <= 1'b0;
                ap_req_addr  <= {sel_port, sel_bank, rd_a};
                ap_req_wdata <= '0;
                pend         <= 1'b1;
                is_rd_q      <= 1'b1;
            end else if (wr_go) begin
                ap_req_valid <= 1'b1;
                ap_req_write <= 1'b1;
                ap_req_addr  <= {sel_port, sel_bank, wr_a};
                ap_req_wdata <= wr_data;
                pend         <= 1'b1;
                is_rd_q      <= 1'b0;
            end else begin
                if (ap_req_valid && ap_req_ready)
                    ap_req_valid <= 1'b0;
                if (ap_rsp_valid && pend) begin
                    pend <= 1'b0;
                    if (is_rd_q)
                        rdbuf <= ap_rsp_rdata;
                end
            end
        end
    end

endmodule

// File: rtl/swdt_target.sv
module swdt_target
    import swdt_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h5A1D_0C01,
    parameter int APSEL_W = 8,
    parameter int BANK_W  = 4,
    localparam int AW = APSEL_W + BANK_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_in,
    output logic          sw_out,
    output logic          sw_oe,
    output logic          ap_req_valid,
    input  logic          ap_req_ready,
    output logic          ap_req_write,
    output logic [AW-1:0] ap_req_addr,
    output logic [31:0]   ap_req_wdata,
    input  logic          ap_rsp_valid,
    input  logic [31:0]   ap_rsp_rdata
);

    logic                   ap_pend, sticky_err;
    logic [DATA_W-1:0]      rdbuf, rd_value, wr_data;
    logic [3:0][DATA_W-1:0] dp_rd;
    logic                   dec_ap, rd_launch, wr_commit, wr_par_err, wr_ap;
    logic [1:0]             dec_a, wr_a;
    logic [APSEL_W-1:0]     sel_port;
    logic [BANK_W-1:0]      sel_bank;

    assign rd_value = dec_ap ? rdbuf : dp_rd[dec_a];

    swdt_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_in      (sw_in),
        .sw_out     (sw_out),
        .sw_oe      (sw_oe),
        .ap_busy    (ap_pend),
        .sticky_err (sticky_err),
        .rd_value   (rd_value),
        .dec_ap     (dec_ap),
        .dec_a      (dec_a),
        .rd_launch  (rd_launch),
        .wr_commit  (wr_commit),
        .wr_par_err (wr_par_err),
        .wr_ap      (wr_ap),
        .wr_a       (wr_a),
        .wr_data    (wr_data)
    );

    swdt_dp_regs #(
        .ID_VALUE (ID_VALUE),
        .APSEL_W  (APSEL_W),
        .BANK_W   (BANK_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit  (wr_commit),
        .wr_ap      (wr_ap),
        .wr_a       (wr_a),
        .wr_data    (wr_data),
        .wr_par_err (wr_par_err),
        .ap_pend    (ap_pend),
        .rdbuf      (rdbuf),
        .sel_port   (sel_port),
        .sel_bank   (sel_bank),
        .sticky_err (sticky_err),
        .dp_rd      (dp_rd)
    );

    swdt_ap_port #(
        .APSEL_W (APSEL_W),
        .BANK_W  (BANK_W)
    ) u_ap (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_launch    (rd_launch),
        .rd_a         (dec_a),
        .wr_go        (wr_commit && wr_ap),
        .wr_a         (wr_a),
        .wr_data      (wr_data),
        .sel_port     (sel_port),
        .sel_bank     (sel_bank),
        .ap_req_valid (ap_req_valid),
        .ap_req_ready (ap_req_ready),
        .ap_req_write (ap_req_write),
        .ap_req_addr  (ap_req_addr),
        .ap_req_wdata (ap_req_wdata),
        .ap_rsp_valid (ap_rsp_valid),
        .ap_rsp_rdata (ap_rsp_rdata),
        .pend         (ap_pend),
        .rdbuf        (rdbuf)
    );

endmodule

// File: rtl/swdt_target_chk.sv
module swdt_target_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_oe,
    input logic          ap_req_valid,
    input logic          ap_req_ready,
    input logic          ap_req_write,
    input logic [AW-1:0] ap_req_addr,
    input logic [31:0]   ap_req_wdata,
    input logic          ap_rsp_valid
);

    logic [5:0] oe_run_q;
    logic       out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_run_q <= '0;
            out_q    <= 1'b0;
        end else begin
            oe_run_q <= sw_oe ? oe_run_q + 6'd1 : 6'd0;
            if (ap_req_valid && ap_req_ready) out_q <= 1'b1;
            else if (ap_rsp_valid)            out_q <= 1'b0;
        end
    end

    // R3
    oe_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_oe |-> oe_run_q < 6'd36);

    // R3
    ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_oe) |=> sw_oe ##1 sw_oe);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid && !ap_req_ready |=> ap_req_valid && $stable(ap_req_addr)
            && $stable(ap_req_wdata) && $stable(ap_req_write));

    // R9
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid && ap_req_ready |=> !ap_req_valid);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !ap_req_valid);

endmodule

bind swdt_target swdt_target_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_oe        (sw_oe),
    .ap_req_valid (ap_req_valid),
    .ap_req_ready (ap_req_ready),
    .ap_req_write (ap_req_write),
    .ap_req_addr  (ap_req_addr),
    .ap_req_wdata (ap_req_wdata),
    .ap_rsp_valid (ap_rsp_valid)
);

// File: tb/swdt_target_tb_top.sv
`timescale 1ns/1ps
module swdt_target_tb_top;

    localparam logic [31:0] ID = 32'h5A1D_0C01;
    localparam logic [2:0] OK = 3'b001, WT = 3'b010, FT = 3'b100;

    logic clk = 1'b0;
    logic rst_n;
    logic sw_in;
    logic sw_out, sw_oe;
    logic ap_req_valid, ap_req_ready, ap_req_write, ap_rsp_valid;
    logic [13:0] ap_req_addr;
    logic [31:0] ap_req_wdata, ap_rsp_rdata;

    int checks = 0;
    int errors = 0;
    int rdy_dly = 0;
    int lat = 2;
    int req_count = 0;
    int rd_idx = 0;
    logic [13:0] log_addr;
    logic        log_write;
    logic [31:0] log_wdata;

    always #2.5 clk = ~clk;

    swdt_target #(.ID_VALUE(ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .sw_out(sw_out), .sw_oe(sw_oe),
        .ap_req_valid(ap_req_valid), .ap_req_ready(ap_req_ready),
        .ap_req_write(ap_req_write), .ap_req_addr(ap_req_addr),
        .ap_req_wdata(ap_req_wdata), .ap_rsp_valid(ap_rsp_valid),
        .ap_rsp_rdata(ap_rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // access-port responder
    initial begin
        int wait_cnt = 0;
        int rsp_cnt = 0;
        bit rsp_pend = 0;
        bit rsp_rd = 0;
        ap_req_ready = 1'b0;
        ap_rsp_valid = 1'b0;
        ap_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            ap_rsp_valid = 1'b0;
            if (rsp_pend) begin
                if (rsp_cnt == 0) begin
                    ap_rsp_valid = 1'b1;
                    ap_rsp_rdata = rsp_rd ? 32'hC0DE_0000 + rd_idx : 32'h0;
                    if (rsp_rd) rd_idx++;
                    rsp_pend = 0;
                end else rsp_cnt--;
            end
            ap_req_ready = ap_req_valid && (wait_cnt >= rdy_dly);
            if (ap_req_ready) begin
                log_addr  = ap_req_addr;
                log_write = ap_req_write;
                log_wdata = ap_req_wdata;
                req_count++;
                rsp_pend  = 1;
                rsp_cnt   = lat;
                rsp_rd    = !ap_req_write;
                wait_cnt  = 0;
            end else if (ap_req_valid) wait_cnt++;
        end
    end

    task automatic bit_cyc(input logic v, output logic o, output logic e);
        @(negedge clk);
        o = sw_out;
        e = sw_oe;
        sw_in = v;
    endtask

    // one host transaction; line_ok = sw_oe pattern as expected
    task automatic xfer(input logic ap, input logic rd, input logic [1:0] a,
                        input logic [31:0] wd, input int bad, input logic wflip,
                        output logic [2:0] ack, output logic [31:0] rdat,
                        output logic rpar_ok, output logic line_ok);
        logic [7:0] r;
        logic o, e;
        r = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
        if (bad == 1) r[5] = ~r[5];
        if (bad == 2) r[6] = 1'b1;
        if (bad == 3) r[7] = 1'b0;
        ack = 3'b000; rdat = '0; rpar_ok = 1'b1; line_ok = 1'b1;
        for (int i = 0; i < 8; i++) bit_cyc(r[i], o, e);
        bit_cyc(1'b0, o, e);
        if (e) line_ok = 1'b0;
        for (int i = 0; i < 3; i++) begin
            bit_cyc(1'b0, o, e);
            if (bad != 0) begin
                if (e) line_ok = 1'b0;
            end else begin
                if (!e) line_ok = 1'b0;
                ack[i] = e & o;
            end
        end
        if (bad == 0 && ack == OK && rd) begin
            for (int i = 0; i < 32; i++) begin
                bit_cyc(1'b0, o, e);
                rdat[i] = o;
                if (!e) line_ok = 1'b0;
            end
            bit_cyc(1'b0, o, e);
            if (!e) line_ok = 1'b0;
            rpar_ok = (o == ^rdat);
            bit_cyc(1'b0, o, e);
            if (e) line_ok = 1'b0;
        end else if (bad == 0 && ack == OK) begin
            bit_cyc(1'b0, o, e);
            if (e) line_ok = 1'b0;
            for (int i = 0; i < 32; i++) begin
                bit_cyc(wd[i], o, e);
                if (e) line_ok = 1'b0;
            end
            bit_cyc((^wd) ^ wflip, o, e);
            if (e) line_ok = 1'b0;
        end else begin
            bit_cyc(1'b0, o, e);
            if (e) line_ok = 1'b0;
        end
        bit_cyc(1'b0, o, e);
        if (e) line_ok = 1'b0;
    endtask

    task automatic do_read(input string tag, input logic ap, input logic [1:0] a,
                           input logic [2:0] exp_ack, input logic [31:0] exp_data);
        logic [2:0] ack; logic [31:0] d; logic p, l;
        xfer(ap, 1'b1, a, '0, 0, 1'b0, ack, d, p, l);
        chk({tag, " ack"}, 32'(ack), 32'(exp_ack));
        chk({tag, " R3 line"}, 32'(l), 32'd1);
        if (exp_ack == OK) begin
            chk({tag, " data"}, d, exp_data);
            chk({tag, " R4 parity"}, 32'(p), 32'd1);
        end
    endtask

    task automatic do_write(input string tag, input logic ap, input logic [1:0] a,
                            input logic [31:0] wd, input logic wflip,
                            input logic [2:0] exp_ack);
        logic [2:0] ack; logic [31:0] d; logic p, l;
        xfer(ap, 1'b0, a, wd, 0, wflip, ack, d, p, l);
        chk({tag, " ack"}, 32'(ack), 32'(exp_ack));
        chk({tag, " R3 line"}, 32'(l), 32'd1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 oe after reset", 32'(sw_oe), 32'd0);
        chk("R11 valid after reset", 32'(ap_req_valid), 32'd0);
        do_read("R6 R1 id read", 1'b0, 2'b00, OK, ID);
        do_read("R11 status reset", 1'b0, 2'b01, OK, 32'h0);
        do_read("R11 select reset", 1'b0, 2'b10, OK, 32'h0);
        do_read("R11 rdbuf reset", 1'b0, 2'b11, OK, 32'h0);
    endtask

    task automatic t_select;
        do_write("R6 select all ones", 1'b0, 2'b10, 32'hFFFF_FFFF, 1'b0, OK);
        do_read("R6 select reserved zero", 1'b0, 2'b10, OK, 32'hFF00_00F0);
        do_write("R6 select set", 1'b0, 2'b10, 32'h3C00_0050, 1'b0, OK);
        do_write("R6 rdbuf write ignored", 1'b0, 2'b11, 32'h1234_5678, 1'b0, OK);
        do_read("R6 rdbuf unchanged", 1'b0, 2'b11, OK, 32'h0);
        do_write("R6 status write ignored", 1'b0, 2'b01, 32'hFFFF_FFFF, 1'b0, OK);
        do_read("R6 status unchanged", 1'b0, 2'b01, OK, 32'h0);
    endtask

    task automatic t_ap_write;
        int n0;
        n0 = req_count;
        rdy_dly = 3;
        do_write("R5 R7 ap write", 1'b1, 2'b01, 32'hDEAD_BEEF, 1'b0, OK);
        idle(10);
        chk("R7 write count", 32'(req_count - n0), 32'd1);
        chk("R7 write addr", 32'(log_addr), 32'({8'h3C, 4'h5, 2'b01}));
        chk("R7 write flag", 32'(log_write), 32'd1);
        chk("R5 write data", log_wdata, 32'hDEAD_BEEF);
        rdy_dly = 0;
    endtask

    task automatic t_ap_read;
        int n0;
        n0 = req_count;
        do_read("R8 first posted", 1'b1, 2'b10, OK, 32'h0);
        idle(6);
        chk("R8 read addr", 32'(log_addr), 32'({8'h3C, 4'h5, 2'b10}));
        chk("R8 read flag", 32'(log_write), 32'd0);
        do_read("R8 second posted", 1'b1, 2'b11, OK, 32'hC0DE_0000);
        idle(6);
        do_read("R8 dp rdbuf", 1'b0, 2'b11, OK, 32'hC0DE_0001);
        idle(4);
        chk("R8 rdbuf no launch", 32'(req_count - n0), 32'd2);
    endtask

    task automatic t_wait;
        int n0;
        lat = 150;
        do_read("R9 slow launch", 1'b1, 2'b00, OK, 32'hC0DE_0001);
        n0 = req_count;
        do_read("R9 wait ack", 1'b1, 2'b00, WT, 32'h0);
        do_write("R9 wait write", 1'b1, 2'b00, 32'h1, 1'b0, WT);
        chk("R9 no extra request", 32'(req_count - n0), 32'd0);
        do_read("R6 R9 status pending", 1'b0, 2'b01, OK, 32'h2);
        idle(200);
        lat = 2;
        do_read("R9 retry ok", 1'b1, 2'b00, OK, 32'hC0DE_0002);
        idle(6);
    endtask

    task automatic t_bad_req;
        logic [2:0] ack; logic [31:0] d; logic p, l;
        int n0;
        n0 = req_count;
        for (int k = 1; k < 4; k++) begin
            xfer(1'b1, 1'b1, 2'b01, '0, k, 1'b0, ack, d, p, l);
            chk($sformatf("R2 malformed %0d undriven", k), 32'(l), 32'd1);
        end
        chk("R2 no request", 32'(req_count - n0), 32'd0);
        do_read("R2 R1 recover", 1'b0, 2'b10, OK, 32'h3C00_0050);
    endtask

    task automatic t_par_err;
        int n0;
        do_write("R5 bad parity write", 1'b0, 2'b10, 32'hAA00_00A0, 1'b1, OK);
        do_read("R5 select kept", 1'b0, 2'b10, OK, 32'h3C00_0050);
        do_read("R5 sticky set", 1'b0, 2'b01, OK, 32'h1);
        n0 = req_count;
        do_read("R10 fault read", 1'b1, 2'b01, FT, 32'h0);
        do_write("R10 fault write", 1'b1, 2'b01, 32'h5, 1'b0, FT);
        idle(6);
        chk("R10 no request", 32'(req_count - n0), 32'd0);
        do_write("R6 clear sticky", 1'b0, 2'b00, 32'h1, 1'b0, OK);
        do_read("R6 sticky clear", 1'b0, 2'b01, OK, 32'h0);
        do_read("R10 ok after clear", 1'b1, 2'b01, OK, 32'hC0DE_0003);
        idle(6);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        sw_in = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_select();
        t_ap_write();
        t_ap_read();
        t_wait();
        t_bad_req();
        t_par_err();
        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule